// File: doc/BRIEF.md
# Transmit Completion Status Stack

The block keeps a short last-in, first-out record of finished transmissions. Each time the transmit MAC reports the end of a frame, a status byte is built from its flags and placed on top of the stack. The host sees the most recent byte on a read port. Any host write to that port removes the top entry; the write data is not used. While the top entry reports an error or asks for an interrupt, the block raises an event toward the interrupt controller.

A jabber or underrun completion is fatal. It drops the transmitter-enable output, and only the transmit reset input raises it again. The same reset also empties the stack. If a completion arrives while the stack is full and no pop happens in the same cycle, the new status is dropped. The loss is then marked in the entry already on top.

Two small state machines do the control. The occupancy machine has the states OCC_EMPTY, OCC_PART and OCC_FULL. Its next state follows the entry count after the cycle's operation: a push moves EMPTY to PART, or to FULL when the last slot fills. A pop moves FULL to PART and moves PART to EMPTY on the last entry. Transmit reset returns any state to OCC_EMPTY. The enable machine has the states TXE_ON and TXE_HALT. A fatal completion moves TXE_ON to TXE_HALT, and only transmit reset moves TXE_HALT back to TXE_ON.

Top module: `txdone_stack`

## Requirements
- R1: A completion pushes the byte {bit7=1, bit6=interrupt request, bit5=jabber, bit4=underrun, bit3=maximum collisions, bit2=0, bits1..0=0}. That byte is shown on host_rd_data in the cycle after the strobe.
- R2: Entries leave in last-in, first-out order. Each host_wr pops the top entry and shows the one beneath it.
- R3: An empty stack reads 0x00, and a host_wr on an empty stack has no effect.
- R4: A completion on a full stack with no pop in the same cycle is dropped. It sets bit 2 of the top entry and leaves all other entries unchanged.
- R5: When host_wr and cmp_stb come in the same cycle, the pop is done first and the push second. On a full stack this replaces the top entry and does not set bit 2.
- R6: txc_event is high exactly when the stack is non-empty and the top entry has any of bits 6, 5, 4, 3 or 2 set.
- R7: A completion with jabber or underrun drives tx_enabled low from the next cycle on. tx_enabled stays low through later completions and pops until tx_rst.
- R8: tx_rst empties the stack, clears any overflow mark and raises tx_enabled. It overrides a strobe or pop in the same cycle.
- R9: After rst_n the stack is empty: host_rd_data is 0x00, txc_event is low and tx_enabled is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_rst | input | 1 | Synchronous transmit reset: empties the stack and re-enables the transmitter |
| cmp_stb | input | 1 | One-cycle transmission-finished strobe from the MAC |
| cmp_jabber | input | 1 | The finished frame had a jabber error |
| cmp_underrun | input | 1 | The finished frame had an underrun |
| cmp_maxcol | input | 1 | The finished frame hit the collision limit |
| cmp_intreq | input | 1 | An interrupt on success was requested for this frame |
| host_wr | input | 1 | Host write to the status port; pops the top entry |
| host_rd_data | output | 8 | Top status byte, or 0x00 when the stack is empty |
| txc_event | output | 1 | Transmit-complete event to the interrupt controller |
| tx_enabled | output | 1 | Low while a fatal completion waits for transmit reset |

## Verification
The hardest state to reach is a full stack that receives a completion. Two cases need care there: with no pop in the same cycle, the top entry must be marked and not overwritten; with a pop in the same cycle, the top entry must be replaced cleanly. The vector table first fills the stack with distinguishable bytes. It then strobes once alone and once together with a write, and pops down through the stack to show that the lower entries were untouched. The fatal halt is checked the same way: pops and completions are applied while halted, and the bench confirms that only transmit reset, even one given together with a strobe, raises the enable again.

// File: rtl/txs_pkg.sv
package txs_pkg;

    localparam int BIT_DONE  = 7;
    localparam int BIT_IRQ   = 6;
    localparam int BIT_JAB   = 5;
    localparam int BIT_UND   = 4;
    localparam int BIT_MCOL  = 3;
    localparam int BIT_OVF   = 2;

    // bits that make the top entry raise the completion event
    localparam logic [7:0] EVENT_MASK = 8'h7C;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_t;

    typedef enum logic {
        TXE_ON   = 1'b0,
        TXE_HALT = 1'b1
    } txe_t;

    typedef struct packed {
        logic irq;
        logic jab;
        logic und;
        logic mcol;
    } cmp_flags_t;

endpackage

// File: rtl/txs_fmt.sv
module txs_fmt
    import txs_pkg::*;
(
    input  cmp_flags_t flags,
    output logic [7:0] status,
    output logic       fatal
);

    always_comb begin
        status           = 8'h00;
        status[BIT_DONE] = 1'b1;
        status[BIT_IRQ]  = flags.irq;
        status[BIT_JAB]  = flags.jab;
        status[BIT_UND]  = flags.und;
        status[BIT_MCOL] = flags.mcol;
        fatal            = flags.jab | flags.und;
    end

endmodule

// File: rtl/txs_ctrl.sv
module txs_ctrl
    import txs_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int IDXW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_rst,
    input  logic            push,
    input  logic            pop,
    input  logic            fatal,
    output logic            push_en,
    output logic [IDXW-1:0] push_idx,
    output logic            merge_en,
    output logic [IDXW-1:0] merge_idx,
    output logic [IDXW-1:0] top_idx,
    output logic            empty,
    output logic            tx_en
);

    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    occ_t            occ_q, occ_n;
    txe_t            txe_q, txe_n;
    logic [CW-1:0]   cnt_q, cnt_n;
    logic [CW-1:0]   base;
    logic            do_pop;

    // next-state and operation decode
    always_comb begin
        do_pop   = pop && (occ_q != OCC_EMPTY);
        base     = cnt_q - CW'(do_pop);
        push_en  = push && (base < FULLC);
        merge_en = push && !do_pop && (occ_q == OCC_FULL);
        cnt_n    = base + CW'(push_en);
        if (tx_rst) begin
            push_en  = 1'b0;
            merge_en = 1'b0;
            cnt_n    = '0;
        end
        if (cnt_n == '0)        occ_n = OCC_EMPTY;
        else if (cnt_n == FULLC) occ_n = OCC_FULL;
        else                     occ_n = OCC_PART;

        txe_n = txe_q;
        unique case (txe_q)
            TXE_ON:   if (!tx_rst && push && fatal) txe_n = TXE_HALT;
            TXE_HALT: if (tx_rst)                   txe_n = TXE_ON;
            default:  txe_n = TXE_ON;
        endcase
    end

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q <= OCC_EMPTY;
            txe_q <= TXE_ON;
            cnt_q <= '0;
        end else begin
            occ_q <= occ_n;
            txe_q <= txe_n;
            cnt_q <= cnt_n;
        end
    end

    // outputs
    always_comb begin
        push_idx  = IDXW'(base);
        merge_idx = IDXW'(DEPTH - 1);
        top_idx   = IDXW'(cnt_q - CW'(1));
        unique case (occ_q)
            OCC_EMPTY: empty = 1'b1;
            OCC_PART:  empty = 1'b0;
            OCC_FULL:  empty = 1'b0;
            default:   empty = 1'b1;
        endcase
        tx_en = (txe_q == TXE_ON);
    end

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULLC);

    p_pop_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);

    p_rst_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rst |=> (empty && tx_en));

    p_fatal_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && fatal && !tx_rst) |=> !tx_en);

    p_halt_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !tx_rst) |=> !tx_en);

endmodule

// File: rtl/txs_lifo.sv
module txs_lifo
    import txs_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int IDXW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_en,
    input  logic [IDXW-1:0] push_idx,
    input  logic [7:0]      push_data,
    input  logic            merge_en,
    input  logic [IDXW-1:0] merge_idx,
    input  logic [IDXW-1:0] top_idx,
    output logic [7:0]      top_data
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else begin
            if (push_en)
                mem[push_idx] <= push_data;
            if (merge_en)
                mem[merge_idx][BIT_OVF] <= 1'b1;
        end
    end

    assign top_data = mem[top_idx];

    p_push_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |=> (mem[$past(push_idx)] == $past(push_data)));

    p_merge_sets_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        merge_en |=> mem[DEPTH-1][BIT_OVF]);

    p_merge_keeps_rest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        merge_en |=> (mem[DEPTH-1][7:3] == $past(mem[DEPTH-1][7:3])));

endmodule

// File: rtl/txdone_stack.sv
module txdone_stack
    import txs_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_rst,
    input  logic       cmp_stb,
    input  logic       cmp_jabber,
    input  logic       cmp_underrun,
    input  logic       cmp_maxcol,
    input  logic       cmp_intreq,
    input  logic       host_wr,
    output logic [7:0] host_rd_data,
    output logic       txc_event,
    output logic       tx_enabled
);

    localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW   = $clog2(DEPTH + 1);

    cmp_flags_t      flags;
    logic [7:0]      new_status;
    logic            fatal;
    logic            push_en, merge_en, empty;
    logic [IDXW-1:0] push_idx, merge_idx, top_idx;
    logic [7:0]      top_data;

    assign flags = '{irq: cmp_intreq, jab: cmp_jabber, und: cmp_underrun, mcol: cmp_maxcol};

    txs_fmt u_fmt (
        .flags  (flags),
        .status (new_status),
        .fatal  (fatal)
    );

    txs_ctrl #(.DEPTH(DEPTH), .IDXW(IDXW), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_rst    (tx_rst),
        .push      (cmp_stb),
        .pop       (host_wr),
        .fatal     (fatal),
        .push_en   (push_en),
        .push_idx  (push_idx),
        .merge_en  (merge_en),
        .merge_idx (merge_idx),
        .top_idx   (top_idx),
        .empty     (empty),
        .tx_en     (tx_enabled)
    );

    txs_lifo #(.DEPTH(DEPTH), .IDXW(IDXW)) u_lifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (push_en),
        .push_idx  (push_idx),
        .push_data (new_status),
        .merge_en  (merge_en),
        .merge_idx (merge_idx),
        .top_idx   (top_idx),
        .top_data  (top_data)
    );

    assign host_rd_data = empty ? 8'h00 : top_data;
    assign txc_event    = !empty && ((top_data & EVENT_MASK) != 8'h00);

    p_event_has_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        txc_event |-> host_rd_data[BIT_DONE]);

    p_low_bits_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_data[1:0] == 2'b00);

endmodule

// File: tb/sim_txdone_stack.sv
`timescale 1ns/1ps
module sim_txdone_stack;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_rst = 1'b0, cmp_stb = 1'b0, cmp_jabber = 1'b0;
    logic       cmp_underrun = 1'b0, cmp_maxcol = 1'b0, cmp_intreq = 1'b0, host_wr = 1'b0;
    logic [7:0] host_rd_data;
    logic       txc_event, tx_enabled;

    int n_run = 0, n_fail = 0, cycles = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    txdone_stack #(.DEPTH(4)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_rst(tx_rst), .cmp_stb(cmp_stb),
        .cmp_jabber(cmp_jabber), .cmp_underrun(cmp_underrun),
        .cmp_maxcol(cmp_maxcol), .cmp_intreq(cmp_intreq), .host_wr(host_wr),
        .host_rd_data(host_rd_data), .txc_event(txc_event), .tx_enabled(tx_enabled)
    );

    // {rst,stb,jab,und,mcol,irq,pop}, expected read byte, {event,enabled}, requirement
    localparam int NV = 35;
    localparam logic [20:0] VEC [NV] = '{
        {7'b0000000, 8'h00, 2'b01, 4'd9},  // R9 idle
        {7'b0000001, 8'h00, 2'b01, 4'd3},  // R3 pop on empty
        {7'b0100000, 8'h80, 2'b01, 4'd1},  // R1 plain
        {7'b0100010, 8'hC0, 2'b11, 4'd6},  // R6 irq raises event
        {7'b0100100, 8'h88, 2'b11, 4'd1},  // R1 max collisions
        {7'b0000001, 8'hC0, 2'b11, 4'd2},  // R2 LIFO
        {7'b0000001, 8'h80, 2'b01, 4'd2},
        {7'b0100100, 8'h88, 2'b11, 4'd1},
        {7'b0100000, 8'h80, 2'b01, 4'd6},
        {7'b0100010, 8'hC0, 2'b11, 4'd1},  // now full
        {7'b0100100, 8'hC4, 2'b11, 4'd4},  // R4 overflow merged into top
        {7'b0000001, 8'h80, 2'b01, 4'd4},  // R4 lower entry untouched
        {7'b0100011, 8'hC0, 2'b11, 4'd5},  // R5 pop then push
        {7'b0100000, 8'h80, 2'b01, 4'd1},  // full again
        {7'b0100011, 8'hC0, 2'b11, 4'd5},  // R5 full: replace, no overflow
        {7'b0000001, 8'hC0, 2'b11, 4'd5},
        {7'b0000001, 8'h88, 2'b11, 4'd2},
        {7'b0000001, 8'h80, 2'b01, 4'd2},
        {7'b0000001, 8'h00, 2'b01, 4'd3},
        {7'b0101000, 8'h90, 2'b10, 4'd7},  // R7 underrun halts
        {7'b0100000, 8'h80, 2'b00, 4'd7},
        {7'b0000001, 8'h90, 2'b10, 4'd7},
        {7'b0000001, 8'h00, 2'b00, 4'd7},
        {7'b0110000, 8'hA0, 2'b10, 4'd7},  // R7 jabber
        {7'b1100010, 8'h00, 2'b01, 4'd8},  // R8 reset wins over strobe
        {7'b0110000, 8'hA0, 2'b10, 4'd7},
        {7'b0100000, 8'h80, 2'b00, 4'd1},
        {7'b0100000, 8'h80, 2'b00, 4'd1},
        {7'b0100000, 8'h80, 2'b00, 4'd1},
        {7'b0100000, 8'h84, 2'b10, 4'd4},  // R4 overflow raises event
        {7'b1000000, 8'h00, 2'b01, 4'd8},  // R8 clears all
        {7'b0100000, 8'h80, 2'b01, 4'd8},  // R8 overflow mark gone
        {7'b1000001, 8'h00, 2'b01, 4'd8},
        {7'b0101110, 8'hD8, 2'b10, 4'd1},  // R1 combined flags
        {7'b1000000, 8'h00, 2'b01, 4'd8}
    };

    task automatic check(input string what, input int req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic [6:0] ctl);
        @(negedge clk);
        {tx_rst, cmp_stb, cmp_jabber, cmp_underrun, cmp_maxcol, cmp_intreq, host_wr} = ctl;
        @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        check("reset read", 9, host_rd_data, 8'h00);
        check("reset event", 9, {7'd0, txc_event}, 8'h00);
        check("reset enable", 9, {7'd0, tx_enabled}, 8'h01);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][20:14]);
            check($sformatf("vec %0d read", i), int'(VEC[i][3:0]), host_rd_data, VEC[i][13:6]);
            check($sformatf("vec %0d event", i), int'(VEC[i][3:0]), {7'd0, txc_event}, {7'd0, VEC[i][5]});
            check($sformatf("vec %0d enable", i), int'(VEC[i][3:0]), {7'd0, tx_enabled}, {7'd0, VEC[i][4]});
        end

        // R9: asynchronous reset with entries present and transmitter halted
        step(7'b0110010);
        step(7'b0100000);
        step(7'b0000000);
        check("halt before reset", 7, {7'd0, tx_enabled}, 8'h00);
        @(negedge clk) rst_n = 1'b0;
        #1;
        check("mid-run reset read", 9, host_rd_data, 8'h00);
        check("mid-run reset event", 9, {7'd0, txc_event}, 8'h00);
        check("mid-run reset enable", 9, {7'd0, tx_enabled}, 8'h01);
        @(negedge clk) rst_n = 1'b1;
        // R3: several pops after reset stay empty, then a push still lands at the bottom
        step(7'b0000001);
        step(7'b0000001);
        step(7'b0100100);
        check("push after empty pops", 3, host_rd_data, 8'h88);
        step(7'b0000001);
        check("empty again", 3, host_rd_data, 8'h00);
        step(7'b0000000);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule